// File: doc/BRIEF.md
# SMBus Clock-Low Timeout Monitor

This block watches the synchronized SCL level of an SMBus port together with already-decoded START, STOP and ACK strobes. It enforces three timing limits. The first is one unbroken clock-low interval. The second is the total time the local device, acting as target, holds the clock low across a whole message. The third is the total time the local device, acting as controller, holds the clock low within one byte segment. Time is measured in ticks from an external prescaler, normally one per millisecond. Each limit is a run-time threshold in ticks.

Each check has its own enable, counter and sticky flag. A flag stays set until software pulses the matching clear input. The interrupt output is high while any flag whose check is enabled is set. All pins are plain level or strobe signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `smbus_tmo_mon`

## Requirements
- R1: After reset, all three flags and `irq` are 0 and all counters are 0.
- R2: While `en_low`=1, each cycle with `tick`=1 and `scl_lvl`=0 adds one to the low counter. The counter stops growing once it reaches `thr_low`. `flag_low` is set on the clock edge of a counted tick that brings the count to `thr_low` or beyond.
- R3: Any cycle with `scl_lvl`=1 restarts the low counter at zero.
- R4: The target counter counts a tick only when all of these hold: the bus is inside a message, `tgt_stretch`=1 and `scl_lvl`=0. A repeated START (a START while inside a message) does not restart it. `flag_tgt` is set when a counted tick brings the count to `thr_tgt`.
- R5: The target counter restarts at zero on STOP, and on a START seen outside a message. "Inside a message" becomes true after a START and false after a STOP. STOP wins if both strobes arrive in the same cycle.
- R6: The controller counter counts a tick when the bus is inside a message, `ctl_stretch`=1 and `scl_lvl`=0. It restarts on every START, ACK and STOP. `flag_ctl` is set when a counted tick brings the count to `thr_ctl`.
- R7: A restart condition in the same cycle as a tick wins: the counter becomes zero and no flag is set in that cycle.
- R8: While a check's enable is 0, its counter is held at zero and its flag cannot be set.
- R9: A flag stays set until a cycle with its clear input at 1. A new set in the same cycle as a clear wins over the clear.
- R10: `irq` is 1 exactly when some flag is set and its enable is 1. It follows the flags and enables in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaler time tick, one cycle wide |
| scl_lvl | input | 1 | Synchronized SCL level |
| ev_start | input | 1 | START or repeated START strobe |
| ev_stop | input | 1 | STOP strobe |
| ev_ack | input | 1 | ACK bit strobe |
| tgt_stretch | input | 1 | Local target is holding SCL low |
| ctl_stretch | input | 1 | Local controller is holding SCL low |
| en_low | input | 1 | Enable for the continuous-low check |
| en_tgt | input | 1 | Enable for the target cumulative check |
| en_ctl | input | 1 | Enable for the controller per-byte check |
| thr_low | input | W | Continuous-low limit in ticks |
| thr_tgt | input | W | Target cumulative limit in ticks |
| thr_ctl | input | W | Controller per-byte limit in ticks |
| clr_low | input | 1 | Clear for `flag_low` |
| clr_tgt | input | 1 | Clear for `flag_tgt` |
| clr_ctl | input | 1 | Clear for `flag_ctl` |
| flag_low | output | 1 | Sticky continuous-low timeout |
| flag_tgt | output | 1 | Sticky target cumulative timeout |
| flag_ctl | output | 1 | Sticky controller per-byte timeout |
| irq | output | 1 | OR of the enabled flags |

## Verification
The hardest case to reach is a cumulative stretch total that spans several separate low intervals, with restart strobes arriving on the same cycle as a tick. Random traffic seldom lines these up at the moment a count is one below its threshold. Directed sequences therefore step whole ticks through a message with a repeated START, an ACK that lands together with a tick, and a re-enable after a long disabled stretch. Seeded random bursts with small thresholds then mix low intervals, stretch flags and strobes. A bench model tracks every cycle of these bursts.

// File: rtl/smbtm_pkg.sv
package smbtm_pkg;
  localparam int unsigned NCHK = 3;
  typedef enum logic [1:0] {CHK_LOW = 2'd0, CHK_TGT = 2'd1, CHK_CTL = 2'd2} chk_e;
endpackage

// File: rtl/smbtm_msg.sv
// Tracks whether the bus is inside a message (between START and STOP).
module smbtm_msg (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_start,
  input  logic ev_stop,
  output logic in_msg,
  output logic fresh_start
);
  assign fresh_start = ev_start && !in_msg;

  always_ff @(posedge clk) begin
    if (!rst_n)        in_msg <= 1'b0;
    else if (ev_stop)  in_msg <= 1'b0;   // R5 stop wins
    else if (ev_start) in_msg <= 1'b1;
  end
endmodule

// File: rtl/smbtm_cnt.sv
// One limit counter with a sticky flag.
module smbtm_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic         inc,
  input  logic         restart,
  input  logic [W-1:0] thr,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         flag
);
  logic [W:0] cnt_p1;
  logic       counted;
  logic       hit;

  assign cnt_p1  = {1'b0, cnt} + 1'b1;
  assign counted = en && !restart && tick && inc;
  assign hit     = counted && (cnt_p1 >= {1'b0, thr});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (!en || restart)          cnt <= '0;
      else if (counted && cnt < thr) cnt <= cnt_p1[W-1:0];
      flag <= hit || (flag && !clr);
    end
  end
endmodule

// File: rtl/smbus_tmo_mon.sv
module smbus_tmo_mon #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         scl_lvl,
  input  logic         ev_start,
  input  logic         ev_stop,
  input  logic         ev_ack,
  input  logic         tgt_stretch,
  input  logic         ctl_stretch,
  input  logic         en_low,
  input  logic         en_tgt,
  input  logic         en_ctl,
  input  logic [W-1:0] thr_low,
  input  logic [W-1:0] thr_tgt,
  input  logic [W-1:0] thr_ctl,
  input  logic         clr_low,
  input  logic         clr_tgt,
  input  logic         clr_ctl,
  output logic         flag_low,
  output logic         flag_tgt,
  output logic         flag_ctl,
  output logic         irq
);
  import smbtm_pkg::*;

  logic in_msg, fresh_start;
  logic [NCHK-1:0] en_v, inc_v, rst_v, clr_v, flag_v;
  logic [W-1:0]    thr_v [NCHK];
  logic [W-1:0]    cnt_v [NCHK];
  logic [W-1:0]    cnt_low, cnt_tgt, cnt_ctl;

  smbtm_msg u_msg (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .in_msg(in_msg), .fresh_start(fresh_start)
  );

  // Continuous low: any high sample restarts (R3)
  assign en_v[CHK_LOW]  = en_low;
  assign inc_v[CHK_LOW] = !scl_lvl;
  assign rst_v[CHK_LOW] = scl_lvl;
  assign thr_v[CHK_LOW] = thr_low;
  assign clr_v[CHK_LOW] = clr_low;
  // Target whole message: repeated START keeps the total (R4, R5)
  assign en_v[CHK_TGT]  = en_tgt;
  assign inc_v[CHK_TGT] = in_msg && tgt_stretch && !scl_lvl;
  assign rst_v[CHK_TGT] = ev_stop || fresh_start;
  assign thr_v[CHK_TGT] = thr_tgt;
  assign clr_v[CHK_TGT] = clr_tgt;
  // Controller per byte segment (R6)
  assign en_v[CHK_CTL]  = en_ctl;
  assign inc_v[CHK_CTL] = in_msg && ctl_stretch && !scl_lvl;
  assign rst_v[CHK_CTL] = ev_start || ev_ack || ev_stop;
  assign thr_v[CHK_CTL] = thr_ctl;
  assign clr_v[CHK_CTL] = clr_ctl;

  for (genvar i = 0; i < NCHK; i++) begin : g_chk
    smbtm_cnt #(.W(W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(en_v[i]), .tick(tick), .inc(inc_v[i]),
      .restart(rst_v[i]), .thr(thr_v[i]), .clr(clr_v[i]),
      .cnt(cnt_v[i]), .flag(flag_v[i])
    );
  end

  assign cnt_low  = cnt_v[CHK_LOW];
  assign cnt_tgt  = cnt_v[CHK_TGT];
  assign cnt_ctl  = cnt_v[CHK_CTL];
  assign flag_low = flag_v[CHK_LOW];
  assign flag_tgt = flag_v[CHK_TGT];
  assign flag_ctl = flag_v[CHK_CTL];
  assign irq      = |(flag_v & en_v);
endmodule

// File: rtl/smbtm_chk.sv
module smbtm_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         scl_lvl,
  input logic         ev_ack,
  input logic         ev_stop,
  input logic         en_low,
  input logic         en_ctl,
  input logic         clr_low,
  input logic         clr_tgt,
  input logic         clr_ctl,
  input logic         flag_low,
  input logic         flag_tgt,
  input logic         flag_ctl,
  input logic [W-1:0] cnt_low,
  input logic [W-1:0] cnt_tgt,
  input logic [W-1:0] cnt_ctl
);
  AST_LOW_HIGH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    scl_lvl |=> cnt_low == '0); // R3
  AST_TGT_STOP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> cnt_tgt == '0); // R5
  AST_CTL_ACK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack |=> cnt_ctl == '0); // R6
  AST_OFF_HELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en_ctl |=> cnt_ctl == '0); // R8
  AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_low && !flag_low |=> !flag_low); // R8
  AST_LOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_low && !clr_low |=> flag_low); // R9
  AST_TGT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_tgt && !clr_tgt |=> flag_tgt); // R9
  AST_CTL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ctl && !clr_ctl |=> flag_ctl); // R9
endmodule

bind smbus_tmo_mon smbtm_chk #(.W(W)) u_smbtm_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .ev_ack(ev_ack), .ev_stop(ev_stop),
  .en_low(en_low), .en_ctl(en_ctl), .clr_low(clr_low), .clr_tgt(clr_tgt),
  .clr_ctl(clr_ctl), .flag_low(flag_low), .flag_tgt(flag_tgt), .flag_ctl(flag_ctl),
  .cnt_low(cnt_low), .cnt_tgt(cnt_tgt), .cnt_ctl(cnt_ctl)
);

// File: tb/test_smbus_tmo_mon.sv
module test_smbus_tmo_mon;
  localparam int W = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick, scl, st, sp, ak, ts, cs, el, et, ec, cl, ct, cc;
  logic [W-1:0] tl, tt, tc;
  logic fl, ft, fc, irq;
  int checks = 0, errors = 0, cyc_n = 0;
  int mcnt [3];
  bit mflag [3];
  bit min_msg;

  always #4 clk = ~clk;

  smbus_tmo_mon #(.W(W)) i_smbus_tmo_mon (
    .clk(clk), .rst_n(rst_n), .tick(tick), .scl_lvl(scl), .ev_start(st),
    .ev_stop(sp), .ev_ack(ak), .tgt_stretch(ts), .ctl_stretch(cs),
    .en_low(el), .en_tgt(et), .en_ctl(ec), .thr_low(tl), .thr_tgt(tt),
    .thr_ctl(tc), .clr_low(cl), .clr_tgt(ct), .clr_ctl(cc),
    .flag_low(fl), .flag_tgt(ft), .flag_ctl(fc), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void mstep1(int i, bit en, bit inc, bit rs, int thr, bit clr);
    bit hit;
    hit = en && !rs && tick && inc && (mcnt[i] + 1 >= thr);
    if (!en || rs) mcnt[i] = 0;
    else if (tick && inc && mcnt[i] < thr) mcnt[i]++;
    mflag[i] = hit || (mflag[i] && !clr);
  endfunction

  task automatic mdl();
    if (!rst_n) begin
      foreach (mcnt[i]) begin mcnt[i] = 0; mflag[i] = 0; end
      min_msg = 0;
      return;
    end
    mstep1(0, el, !scl, scl, int'(tl), cl);
    mstep1(1, et, min_msg && ts && !scl, sp || (st && !min_msg), int'(tt), ct);
    mstep1(2, ec, min_msg && cs && !scl, st || ak || sp, int'(tc), cc);
    if (sp) min_msg = 0; else if (st) min_msg = 1;
  endtask

  // one clock: model update after the edge, compare at the falling edge
  task automatic cyc();
    @(posedge clk);
    #1 mdl();
    @(negedge clk);
    cyc_n++;
    if (rst_n) begin
      chk("R2 flag_low", fl, mflag[0]);
      chk("R4 flag_tgt", ft, mflag[1]);
      chk("R6 flag_ctl", fc, mflag[2]);
      chk("R10 irq", irq, int'((mflag[0] && el) || (mflag[1] && et) || (mflag[2] && ec)));
    end
  endtask

  task automatic idle();
    tick = 0; st = 0; sp = 0; ak = 0; cl = 0; ct = 0; cc = 0;
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin tick = 1; cyc(); end
    tick = 0;
  endtask

  task automatic pulse_ev(bit s, bit p, bit a, bit t);
    st = s; sp = p; ak = a; tick = t; cyc(); idle();
  endtask

  task automatic clear_all();
    cl = 1; ct = 1; cc = 1; scl = 1; cyc(); idle();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc_n > 150000) begin errors++; $display("FAIL watchdog"); finish_run(); end
    end
  end

  initial begin
    idle(); scl = 1; ts = 0; cs = 0; el = 0; et = 0; ec = 0;
    tl = 4; tt = 5; tc = 3;
    void'($urandom(32'd20240611));
    repeat (3) cyc();
    rst_n = 1; mdl();
    cyc();
    chk("R1 reset flags", {fl, ft, fc, irq}, 0);

    // R3: high sample restarts the continuous-low count
    el = 1; scl = 0; ticks(3); scl = 1; cyc(); scl = 0; ticks(3);
    chk("R3 restart on high", fl, 0);
    ticks(1);
    chk("R2 low threshold", fl, 1);
    chk("R10 irq with enabled flag", irq, 1);
    scl = 1; cyc();
    chk("R9 sticky flag", fl, 1);
    el = 0; cyc();
    chk("R10 irq masked when disabled", irq, 0);
    cl = 1; cyc(); idle();
    chk("R9 clear", fl, 0);

    // R8: disabled check ignores a long low period; restarts from zero when enabled
    scl = 0; ticks(10);
    chk("R8 disabled no flag", fl, 0);
    el = 1; ticks(3);
    chk("R8 count began at zero", fl, 0);
    ticks(1);
    chk("R8 flag after full limit", fl, 1);
    el = 0; clear_all();

    // R4/R5: target total survives a repeated START
    et = 1; pulse_ev(1, 0, 0, 0);
    scl = 0; ts = 1; ticks(3);
    ts = 0; scl = 1; pulse_ev(1, 0, 0, 0);
    scl = 0; ts = 1; ticks(1);
    chk("R4 repeated start keeps total", ft, 0);
    ticks(1);
    chk("R4 target limit reached", ft, 1);
    ts = 0; clear_all();
    pulse_ev(0, 1, 0, 0); pulse_ev(1, 0, 0, 0);
    scl = 0; ts = 1; ticks(4);
    chk("R5 stop then start restarts", ft, 0);
    ts = 0; scl = 1; pulse_ev(0, 1, 0, 0);
    scl = 0; ts = 1; ticks(6);
    chk("R4 no count outside message", ft, 0);
    ts = 0; et = 0; clear_all();

    // R6/R7: controller per byte segment
    ec = 1; pulse_ev(1, 0, 0, 0);
    scl = 0; cs = 1; ticks(2);
    pulse_ev(0, 0, 1, 1);
    ticks(2);
    chk("R7 ack with tick restarts", fc, 0);
    ticks(1);
    chk("R6 per byte limit", fc, 1);
    // R9: set wins over clear in the same cycle
    cc = 1; tick = 1; cyc(); idle();
    chk("R9 set beats clear", fc, 1);
    cs = 0; scl = 1; pulse_ev(0, 1, 0, 0); clear_all();

    // seeded random traffic with small thresholds
    for (int n = 0; n < 4000; n++) begin
      if (n % 500 == 0) begin
        tl = W'(2 + $urandom_range(0, 8)); tt = W'(2 + $urandom_range(0, 10));
        tc = W'(1 + $urandom_range(0, 5));
        el = 1'($urandom_range(0, 3) != 0); et = 1'($urandom_range(0, 3) != 0);
        ec = 1'($urandom_range(0, 3) != 0);
      end
      tick = 1'($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 9) == 0) scl = ~scl;
      ts = 1'($urandom_range(0, 2) != 0); cs = 1'($urandom_range(0, 2) != 0);
      st = 1'($urandom_range(0, 29) == 0); sp = 1'($urandom_range(0, 39) == 0);
      ak = 1'($urandom_range(0, 19) == 0);
      cl = 1'($urandom_range(0, 49) == 0); ct = 1'($urandom_range(0, 49) == 0);
      cc = 1'($urandom_range(0, 49) == 0);
      cyc();
    end
    idle();
    finish_run();
  end
endmodule